// File: doc/BRIEF.md
# Bus-Master DMA Sequencer

This block is an 8-bit bus-master state machine. It moves words between memory and an I/O endpoint over one shared bidirectional bus, in either direction. A processor pulses `start_i` and then supplies the transfer setup through a 5-bit port over four consecutive cycles. The setup gives the burst mode, the direction, the source address and the destination address. The block then raises its bus request and waits for the grant.

Each word is moved in three steps:
- The block sends the source address and captures the word that the source returns.
- It sends the destination address.
- It forwards the captured word.

Every value the block sends stays on the bus for one cycle before `valid_o` rises, so that endpoints clocked from other domains can sample it safely. One return line, `rtn_i`, serves both as the acknowledge of an address and as the strobe that says returned data is ready. The block passes it through a synchronizer and acts only on its rising edge.

In burst mode four words are moved and both addresses step by one after each word. If an endpoint stays silent too long, the transfer is aborted and reported as failed. Success and failure are told apart by `done_o`.

Top module: `dma_seq`

## Requirements
- R1: While reset is asserted, req_o, wr_en_o, done_o, valid_o, ack_o and tgt_o are all low.
- R2: The block leaves idle only when start_i is high at a clock edge. It then samples cfg_i on the next four edges, in this order: {mode, dir, src[7:5]}, then src[4:0], then {2'b00, dst[7:5]}, then dst[4:0]. mode=1 selects a four-word burst. dir=1 means I/O to memory.
- R3: req_o goes high after the fourth setup cycle. It stays high while grant_i is low and for the rest of the transfer. The transfer begins at the first edge where grant_i is high.
- R4: Each value the block sends is driven for one cycle with valid_o low, and valid_o is high from the second cycle on. The source-address phase lasts exactly two cycles.
- R5: tgt_o=0 addresses memory and tgt_o=1 addresses the I/O endpoint. The source side is tgt_o=dir and the destination side is tgt_o=!dir.
- R6: wr_en_o is low while the source is addressed and while data is received. It is high while the destination address and the data are sent.
- R7: rtn_i passes through a two-flop synchronizer, so a rising edge acts on the third clock edge after it was driven. On a rise in the receive state the block latches the bus and raises ack_o for exactly one cycle. A held-high rtn_i does not act again.
- R8: In the receive state the block releases the bus, so the word driven by the source is captured unchanged and forwarded as data.
- R9: In burst mode exactly four words are moved. Source and destination addresses increment by one, modulo 256, after each word.
- R10: After the last word, req_o goes low and done_o goes high. done_o stays high until the next accepted start.
- R11: If no rising edge is seen within TIMEOUT_CYC cycles of entering the receive, destination-address or data state, the block returns to idle with req_o and done_o low.
- R12: start_i and cfg_i are ignored whenever the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the processor |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins setup when the block is idle |
| grant_i | input | 1 | Bus grant from the processor |
| rtn_i | input | 1 | Asynchronous return strobe from an endpoint |
| cfg_i | input | 5 | Serial setup field |
| req_o | output | 1 | Bus request |
| wr_en_o | output | 1 | High when the addressed endpoint is to be written |
| done_o | output | 1 | Transfer completed successfully |
| valid_o | output | 1 | The value on the bus is stable |
| ack_o | output | 1 | One-cycle receipt of returned data |
| tgt_o | output | 1 | 0 selects memory, 1 selects the I/O endpoint |
| bus_io | inout | 8 | Shared address and data bus |

## Verification
The hardest situations to reach are the abort paths after partial progress. Examples are a source that acknowledges but a destination that never answers, and a rising edge that lands in the last cycle before the limit. The bench reaches them with a responder task that can stop answering at a chosen handshake, and with a behavioural model of the synchronizer delay that predicts the exact abort cycle. The burst run starts at source 0xFE so that the address step crosses 0xFF to 0x00.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT,
    ST_SRC,
    ST_RECV,
    ST_DADR,
    ST_DDAT
  } dma_st_e;

  localparam int CfgBeats = 4;
endpackage

// File: rtl/dma_rtn_sync.sv
module dma_rtn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R7
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dma_timeout.sv
module dma_timeout #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CntW = $clog2(LIMIT + 1);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !en_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (cnt_q == CntW'(LIMIT - 1));

  // R11
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < CntW'(LIMIT)));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CW          = 5,
  parameter int BURST_LEN   = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          grant_i,
  input  logic          rtn_i,
  input  logic [CW-1:0] cfg_i,
  output logic          req_o,
  output logic          wr_en_o,
  output logic          done_o,
  output logic          valid_o,
  output logic          ack_o,
  output logic          tgt_o,
  inout  wire  [AW-1:0] bus_io
);
  localparam int HiW = AW - CW;
  localparam int WcW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int BtW = $clog2(CfgBeats);

  dma_st_e        st_q, st_d;
  logic           ph_q;
  logic [BtW-1:0] beat_q;
  logic [WcW-1:0] word_q;
  logic           mode_q, dir_q, done_q, ack_q;
  logic [AW-1:0]  src_q, dst_q, data_q, dout;
  logic           rise, acc, more, oe, tmo_en, tmo_exp;

  dma_rtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(rtn_i), .rise_o(rise)
  );

  assign tmo_en = (st_q == ST_RECV) || (st_q == ST_DADR) || (st_q == ST_DDAT);

  dma_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tmo_en),
    .clr_i(st_d != st_q), .expire_o(tmo_exp)
  );

  // a handshake counts in receive at once, in send states only after valid
  assign acc  = rise && ((st_q == ST_RECV) || ph_q);
  assign more = mode_q && (word_q != WcW'(BURST_LEN - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_PREP;
      ST_PREP: if (beat_q == BtW'(CfgBeats - 1)) st_d = ST_WAIT;
      ST_WAIT: if (grant_i) st_d = ST_SRC;
      ST_SRC:  if (ph_q) st_d = ST_RECV;
      ST_RECV: if (acc) st_d = ST_DADR; else if (tmo_exp) st_d = ST_IDLE;
      ST_DADR: if (acc) st_d = ST_DDAT; else if (tmo_exp) st_d = ST_IDLE;
      ST_DDAT: if (acc) st_d = more ? ST_SRC : ST_IDLE;
               else if (tmo_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      beat_q <= '0;
      word_q <= '0;
      mode_q <= 1'b0;
      dir_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= (st_d == st_q) &&
               ((st_q == ST_SRC) || (st_q == ST_DADR) || (st_q == ST_DDAT));
      ack_q <= (st_q == ST_RECV) && rise;
      if (st_q == ST_IDLE && start_i) begin
        beat_q <= '0;
        word_q <= '0;
        done_q <= 1'b0;
      end
      if (st_q == ST_PREP) begin
        beat_q <= beat_q + 1'b1;
        unique case (beat_q)
          2'd0: begin
            mode_q           <= cfg_i[CW-1];
            dir_q            <= cfg_i[CW-2];
            src_q[AW-1:CW]   <= cfg_i[HiW-1:0];
          end
          2'd1: src_q[CW-1:0]  <= cfg_i;
          2'd2: dst_q[AW-1:CW] <= cfg_i[HiW-1:0];
          default: dst_q[CW-1:0] <= cfg_i;
        endcase
      end
      if (st_q == ST_RECV && rise) data_q <= bus_io;
      if (st_q == ST_DDAT && acc) begin
        if (more) begin
          word_q <= word_q + 1'b1;
          src_q  <= src_q + 1'b1;
          dst_q  <= dst_q + 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    oe    = 1'b0;
    dout  = src_q;
    tgt_o = 1'b0;
    unique case (st_q)
      ST_SRC:  begin oe = 1'b1; tgt_o = dir_q; end
      ST_RECV: tgt_o = dir_q;
      ST_DADR: begin oe = 1'b1; dout = dst_q;  tgt_o = ~dir_q; end
      ST_DDAT: begin oe = 1'b1; dout = data_q; tgt_o = ~dir_q; end
      default: ;
    endcase
  end

  assign bus_io  = oe ? dout : {AW{1'bz}};
  assign valid_o = oe && ph_q;
  assign req_o   = (st_q != ST_IDLE) && (st_q != ST_PREP);
  assign wr_en_o = (st_q == ST_DADR) || (st_q == ST_DDAT);
  assign done_o  = done_q;
  assign ack_o   = ack_q;

  // R3
  req_after_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> ($past(st_q) == ST_PREP));
  // R4
  valid_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(oe) && $stable(dout)));
  // R6
  wr_in_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> req_o);
  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R10
  done_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
  // R11
  tmo_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_exp && !acc) |=> (st_q == ST_IDLE && !done_o));
endmodule

// File: tb/dma_seq_tb.sv
module dma_seq_tb;
  localparam int TMO = 64;
  localparam int WD_LIMIT = 100000;
  localparam int M_IDLE = 0, M_PREP = 1, M_WAIT = 2, M_SRC = 3,
                 M_RECV = 4, M_DADR = 5, M_DDAT = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 1'b0, grant = 1'b0, rtn = 1'b0;
  logic [4:0] cfg = '0;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_data = '0;
  wire  [7:0] bus_w;
  logic       req, wr, done, valid, ack, tgt;

  assign bus_w = tb_drv ? tb_data : 8'bz;

  dma_seq #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .grant_i(grant),
    .rtn_i(rtn), .cfg_i(cfg), .req_o(req), .wr_en_o(wr), .done_o(done),
    .valid_o(valid), .ack_o(ack), .tgt_o(tgt), .bus_io(bus_w)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int         m_st, m_k, m_tc, m_w;
  bit         m_ph, m_mode, m_dir, m_done, m_ack, m_live, m_rise;
  bit         r1, r2, r3;
  logic [7:0] m_src, m_dst, m_dat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_ph = 0; m_k = 0; m_tc = 0; m_w = 0; m_mode = 0;
      m_dir = 0; m_done = 0; m_ack = 0; m_live = 0; r1 = 0; r2 = 0; r3 = 0;
      m_src = 0; m_dst = 0; m_dat = 0;
    end else begin
      m_rise = r2 && !r3;
      m_ack = 0;
      case (m_st)
        M_IDLE: if (start) begin m_st = M_PREP; m_k = 0; m_w = 0; m_done = 0; end
        M_PREP: begin
          case (m_k)
            0: begin m_mode = cfg[4]; m_dir = cfg[3]; m_src[7:5] = cfg[2:0]; end
            1: m_src[4:0] = cfg;
            2: m_dst[7:5] = cfg[2:0];
            default: m_dst[4:0] = cfg;
          endcase
          if (m_k == 3) m_st = M_WAIT; else m_k++;
        end
        M_WAIT: if (grant) begin m_st = M_SRC; m_ph = 0; end
        M_SRC: if (!m_ph) m_ph = 1; else begin m_st = M_RECV; m_ph = 0; m_tc = 0; end
        M_RECV: begin
          if (m_rise) begin m_dat = bus_w; m_ack = 1; m_st = M_DADR; m_ph = 0; m_tc = 0; end
          else if (m_tc == TMO - 1) m_st = M_IDLE;
          else m_tc++;
        end
        M_DADR: begin
          if (m_ph && m_rise) begin m_st = M_DDAT; m_ph = 0; m_tc = 0; end
          else if (m_tc == TMO - 1) begin m_st = M_IDLE; m_ph = 0; end
          else begin m_tc++; m_ph = 1; end
        end
        default: begin
          if (m_ph && m_rise) begin
            m_ph = 0;
            if (m_mode && m_w < 3) begin
              m_w++; m_src = m_src + 8'd1; m_dst = m_dst + 8'd1; m_st = M_SRC;
            end else begin
              m_st = M_IDLE; m_done = 1;
            end
          end else if (m_tc == TMO - 1) begin m_st = M_IDLE; m_ph = 0; end
          else begin m_tc++; m_ph = 1; end
        end
      endcase
      r3 = r2; r2 = r1; r1 = rtn;
      m_live = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_live) begin
      bit send;
      logic [7:0] eb;
      send = (m_st == M_SRC) || (m_st == M_DADR) || (m_st == M_DDAT);
      eb = (m_st == M_SRC) ? m_src : (m_st == M_DADR) ? m_dst : m_dat;
      chk(req === (m_st >= M_WAIT), "R3 req_o", req, m_st >= M_WAIT);
      chk(wr === (m_st == M_DADR || m_st == M_DDAT), "R6 wr_en_o", wr,
          m_st == M_DADR || m_st == M_DDAT);
      chk(done === m_done, "R10 done_o", done, m_done);
      chk(valid === (send && m_ph), "R4 valid_o", valid, send && m_ph);
      chk(ack === m_ack, "R7 ack_o", ack, m_ack);
      chk(tgt === ((m_st == M_SRC || m_st == M_RECV) ? m_dir :
                   (m_st == M_DADR || m_st == M_DDAT) ? !m_dir : 1'b0),
          "R5 tgt_o", tgt, m_dir);
      if (send) chk(bus_w === eb, "R9 bus_io value", bus_w, eb);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog (all) act=%0d exp=<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic go(input bit mode, input bit dir, input logic [7:0] s, input logic [7:0] d);
    @(negedge clk) start = 1;
    @(negedge clk) begin start = 0; cfg = {mode, dir, s[7:5]}; end
    @(negedge clk) cfg = s[4:0];
    @(negedge clk) cfg = {2'b00, d[7:5]};
    @(negedge clk) cfg = d[4:0];
    @(negedge clk) cfg = '0;
    chk(req === 1'b1, "R3 req after setup", req, 1);
    chk(done === 1'b0, "R10 done cleared by start", done, 0);
  endtask

  task automatic wait_valid(input bit v);
    do @(negedge clk); while (valid !== v);
  endtask

  // stop: 0 full word, 1 silent source, 2 silent destination address
  task automatic serve(input bit dir, input logic [7:0] s, input logic [7:0] dd,
                       input logic [7:0] d, input int dly, input int stop);
    wait_valid(1);
    chk(bus_w === s, "R2 source address", bus_w, s);
    chk(tgt === dir, "R5 source target", tgt, dir);
    chk(wr === 1'b0, "R6 wr_en low on source", wr, 0);
    if (stop == 1) return;
    repeat (dly) @(negedge clk);
    tb_data = d; tb_drv = 1; rtn = 1;
    do @(negedge clk); while (!ack);
    tb_drv = 0; rtn = 0;
    wait_valid(1);
    chk(bus_w === dd, "R2 destination address", bus_w, dd);
    chk(tgt === !dir, "R5 destination target", tgt, !dir);
    chk(wr === 1'b1, "R6 wr_en high on destination", wr, 1);
    if (stop == 2) return;
    repeat (dly) @(negedge clk);
    rtn = 1; wait_valid(0); rtn = 0;
    wait_valid(1);
    chk(bus_w === d, "R8 captured word forwarded", bus_w, d);
    repeat (dly) @(negedge clk);
    rtn = 1; wait_valid(0); rtn = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk({req, wr, done, valid, ack, tgt} === 6'b0, "R1 reset outputs",
        {req, wr, done, valid, ack, tgt}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(req === 1'b0, "R2 stays idle without start", req, 0);

    // single word, memory to I/O, late grant
    go(0, 0, 8'h3C, 8'hA5);
    repeat (4) @(negedge clk);
    chk(req === 1'b1 && valid === 1'b0, "R3 holds for grant", valid, 0);
    grant = 1;
    serve(0, 8'h3C, 8'hA5, 8'h5A, 2, 0);
    grant = 0;
    @(negedge clk);
    chk(done === 1'b1 && req === 1'b0, "R10 completion", {done, req}, 2);
    repeat (10) @(negedge clk);
    chk(done === 1'b1, "R10 done held", done, 1);

    // burst, I/O to memory, source address wraps
    go(1, 1, 8'hFE, 8'h10);
    grant = 1;
    for (int i = 0; i < 4; i++) begin
      serve(1, 8'(8'hFE + i), 8'(8'h10 + i), 8'(8'hC3 ^ i), 1 + i, 0);
      if (i < 3) chk(req === 1'b1, "R9 burst continues", req, 1);
    end
    grant = 0;
    @(negedge clk);
    chk(done === 1'b1 && req === 1'b0, "R9 burst ends after four words", {done, req}, 2);

    // start and setup pulsed while busy
    go(0, 1, 8'h20, 8'h30);
    start = 1; cfg = 5'h1F;
    repeat (3) @(negedge clk);
    start = 0; cfg = '0;
    chk(req === 1'b1, "R12 start ignored while busy", req, 1);
    grant = 1;
    serve(1, 8'h20, 8'h30, 8'h77, 1, 0);
    grant = 0;

    // silent source: abort in receive
    go(1, 0, 8'h40, 8'h50);
    grant = 1;
    serve(0, 8'h40, 8'h50, 8'h00, 1, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (req);
    grant = 0;
    chk(n == TMO + 1, "R11 receive abort cycle", n, TMO + 1);
    chk(done === 1'b0, "R11 receive abort done low", done, 0);

    // silent destination: abort in destination-address state
    go(0, 0, 8'h60, 8'h70);
    grant = 1;
    serve(0, 8'h60, 8'h70, 8'h99, 1, 2);
    n = 0;
    do begin @(negedge clk); n++; end while (req);
    grant = 0;
    chk(n == TMO - 1, "R11 destination abort cycle", n, TMO - 1);
    chk(done === 1'b0, "R11 destination abort done low", done, 0);

    // rtn held high in idle must not act later; recovery after abort
    rtn = 1;
    repeat (4) @(negedge clk);
    go(0, 0, 8'h81, 8'h92);
    grant = 1;
    wait_valid(1);
    repeat (3) @(negedge clk);
    chk(ack === 1'b0 && valid === 1'b0, "R7 held level does not act", ack, 0);
    rtn = 0;
    @(negedge clk);
    tb_data = 8'h3E; tb_drv = 1; rtn = 1;
    do @(negedge clk); while (!ack);
    tb_drv = 0; rtn = 0;
    wait_valid(1);
    @(negedge clk); rtn = 1; wait_valid(0); rtn = 0;
    wait_valid(1);
    chk(bus_w === 8'h3E, "R7 word after fresh edge", bus_w, 8'h3E);
    @(negedge clk); rtn = 1; wait_valid(0); rtn = 0;
    grant = 0;
    @(negedge clk);
    chk(done === 1'b1, "R11 recovers after abort", done, 1);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule